// File: doc/BRIEF.md
# General-Purpose Register File for a 64-bit Core

This block holds sixteen 64-bit integer registers and serves one write port and two read ports in every cycle. Each access gives a register number, an access size and a flag that says whether the instruction carried a REX prefix. From these three fields the block works out which physical register and which bit field the access reaches. This includes the remapping of byte register numbers 4 to 7, which depends on the REX flag.

A write that is narrower than 64 bits follows the 64-bit mode rules. A 32-bit write stores its value and clears the upper half of the register. An 8-bit or 16-bit write replaces only its own field and keeps the rest of the register. Reads return the selected field zero-extended to 64 bits. A read of the register being written in the same cycle sees the merged value that will be stored at the next edge.

A mode input says whether the core is in 64-bit mode. Outside 64-bit mode only registers 0 to 7 exist. An access to registers 8 to 15 is flagged as illegal, and an illegal write is dropped.

Top module: `gpr_file`

## Requirements
- R1: After the asynchronous reset, every register reads as zero.
- R2: In 64-bit mode a qword write (size code 3) to any of registers 0–15 is returned unchanged by a qword read of that register on either read port in a later cycle.
- R3: A byte access (size code 0) with REX absent, or with the mode input low, maps numbers 4, 5, 6 and 7 to bits 15:8 of registers 0, 1, 2 and 3.
- R4: A byte access in 64-bit mode with REX present maps numbers 4–7 to bits 7:0 of registers 4–7, and maps numbers 8–15 to bits 7:0 of registers 8–15; these numbers never reach bits 15:8.
- R5: A dword write (size code 2) stores bits 31:0 of the write data and clears bits 63:32 of the register.
- R6: A byte or word write (size code 1) changes only the addressed 8- or 16-bit field and keeps all other bits of the register.
- R7: A byte, word or dword read returns the addressed field in the low bits of the read data, with all higher bits zero.
- R8: A read of the physical register being written in the same cycle returns the value that the write will store.
- R9: With the mode input low, an access to a register number of 8 or more sets its bit in illegal_o (bit 0 write when enabled, bit 1 port A, bit 2 port B). Such a write leaves every register unchanged, and such a read returns zero. The REX input has no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| long_mode_i | input | 1 | 1 = 64-bit mode |
| wr_en_i | input | 1 | Write enable |
| wr_num_i | input | 4 | Write register number |
| wr_size_i | input | 2 | Write size: 0 byte, 1 word, 2 dword, 3 qword |
| wr_rex_i | input | 1 | REX present on write |
| wr_data_i | input | 64 | Write data, right-aligned |
| ra_num_i | input | 4 | Port A register number |
| ra_size_i | input | 2 | Port A size |
| ra_rex_i | input | 1 | REX present on port A |
| ra_data_o | output | 64 | Port A data, zero-extended |
| rb_num_i | input | 4 | Port B register number |
| rb_size_i | input | 2 | Port B size |
| rb_rex_i | input | 1 | REX present on port B |
| rb_data_o | output | 64 | Port B data, zero-extended |
| illegal_o | output | 3 | Illegal access flags {port B, port A, write} |

## Verification
Read data and illegal flags are combinational, so they are due in the same cycle as the inputs that cause them. A write becomes visible through the array one edge later, and through the bypass at once. The bench applies inputs on the falling edge and compares both read ports and the flags with its model shortly afterwards, in the same cycle. It then updates the model at the rising edge, so the next cycle's expected values already include the write.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_D = 2'd2,
    SZ_Q = 2'd3
  } gpr_size_e;
endpackage

// File: rtl/gpr_port_map.sv
module gpr_port_map
  import gpr_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int LEGACY_REGS = 8,
  localparam int IDX_W      = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0] num_i,
  input  gpr_size_e        size_i,
  input  logic             rex_i,
  input  logic             long_mode_i,
  output logic [IDX_W-1:0] phys_o,
  output logic             hi_o,
  output logic             illegal_o
);
  logic rex_eff;

  // REX only exists in 64-bit mode
  assign rex_eff   = rex_i & long_mode_i;
  assign illegal_o = !long_mode_i && (int'(num_i) >= LEGACY_REGS);

  // numbers 4..7 without REX select bits 15:8 of regs 0..3
  assign hi_o   = (size_i == SZ_B) && !rex_eff && (num_i >= IDX_W'(4)) && (num_i <= IDX_W'(7));
  assign phys_o = hi_o ? {{(IDX_W-2){1'b0}}, num_i[1:0]} : num_i;
endmodule

// File: rtl/gpr_merge.sv
module gpr_merge
  import gpr_pkg::*;
(
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] data_i,
  input  gpr_size_e       size_i,
  input  logic            hi_i,
  output logic [XLEN-1:0] new_o
);
  always_comb begin
    unique case (size_i)
      SZ_B:    new_o = hi_i ? {old_i[XLEN-1:16], data_i[7:0], old_i[7:0]}
                            : {old_i[XLEN-1:8], data_i[7:0]};
      SZ_W:    new_o = {old_i[XLEN-1:16], data_i[15:0]};
      SZ_D:    new_o = {{(XLEN-32){1'b0}}, data_i[31:0]};
      default: new_o = data_i;
    endcase
  end
endmodule

// File: rtl/gpr_extract.sv
module gpr_extract
  import gpr_pkg::*;
(
  input  logic [XLEN-1:0] val_i,
  input  gpr_size_e       size_i,
  input  logic            hi_i,
  input  logic            kill_i,
  output logic [XLEN-1:0] data_o
);
  always_comb begin
    if (kill_i) begin
      data_o = '0;
    end else begin
      unique case (size_i)
        SZ_B:    data_o = {{(XLEN-8){1'b0}}, hi_i ? val_i[15:8] : val_i[7:0]};
        SZ_W:    data_o = {{(XLEN-16){1'b0}}, val_i[15:0]};
        SZ_D:    data_o = {{(XLEN-32){1'b0}}, val_i[31:0]};
        default: data_o = val_i;
      endcase
    end
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int LEGACY_REGS = 8,
  localparam int IDX_W      = $clog2(NUM_REGS),
  localparam int NPORT      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             long_mode_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_num_i,
  input  logic [1:0]       wr_size_i,
  input  logic             wr_rex_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] ra_num_i,
  input  logic [1:0]       ra_size_i,
  input  logic             ra_rex_i,
  output logic [XLEN-1:0]  ra_data_o,
  input  logic [IDX_W-1:0] rb_num_i,
  input  logic [1:0]       rb_size_i,
  input  logic             rb_rex_i,
  output logic [XLEN-1:0]  rb_data_o,
  output logic [NPORT-1:0] illegal_o
);
  // port 0 = write, 1 = read A, 2 = read B
  logic [NUM_REGS-1:0][XLEN-1:0] reg_q;
  logic [NPORT-1:0][IDX_W-1:0]   num;
  logic [NPORT-1:0][1:0]         size;
  logic [NPORT-1:0]              rex;
  logic [NPORT-1:0][IDX_W-1:0]   phys;
  logic [NPORT-1:0]              hi;
  logic [NPORT-1:0]              ill;
  logic [XLEN-1:0]               wr_new;
  logic                          wr_ok;
  logic [NPORT-1:0][XLEN-1:0]    rd_data;

  assign num  = {rb_num_i,  ra_num_i,  wr_num_i};
  assign size = {rb_size_i, ra_size_i, wr_size_i};
  assign rex  = {rb_rex_i,  ra_rex_i,  wr_rex_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    gpr_port_map #(
      .NUM_REGS   (NUM_REGS),
      .LEGACY_REGS(LEGACY_REGS)
    ) i_map (
      .num_i      (num[p]),
      .size_i     (gpr_size_e'(size[p])),
      .rex_i      (rex[p]),
      .long_mode_i(long_mode_i),
      .phys_o     (phys[p]),
      .hi_o       (hi[p]),
      .illegal_o  (ill[p])
    );
  end

  assign wr_ok     = wr_en_i && !ill[0];
  assign illegal_o = {ill[2], ill[1], ill[0] & wr_en_i};

  gpr_merge i_merge (
    .old_i (reg_q[phys[0]]),
    .data_i(wr_data_i),
    .size_i(gpr_size_e'(wr_size_i)),
    .hi_i  (hi[0]),
    .new_o (wr_new)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 reg_q[r] <= '0;
      else if (wr_ok && phys[0] == IDX_W'(r))      reg_q[r] <= wr_new;
    end
  end

  for (genvar p = 1; p < NPORT; p++) begin : g_rd
    logic [XLEN-1:0] raw;
    // write-through bypass
    assign raw = (wr_ok && phys[p] == phys[0]) ? wr_new : reg_q[phys[p]];
    gpr_extract i_ext (
      .val_i (raw),
      .size_i(gpr_size_e'(size[p])),
      .hi_i  (hi[p]),
      .kill_i(ill[p]),
      .data_o(rd_data[p])
    );
  end

  assign ra_data_o = rd_data[1];
  assign rb_data_o = rd_data[2];

  // R5
  upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && wr_size_i == 2'(SZ_D)) |=> (reg_q[$past(phys[0])][XLEN-1:32] == '0));

  // R6
  word_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && wr_size_i == 2'(SZ_W))
      |=> (reg_q[$past(phys[0])][XLEN-1:16] == $past(reg_q[phys[0]][XLEN-1:16])));

  // R9
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o[0] |=> $stable(reg_q));

  // R9
  illegal_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o[1] |-> (ra_data_o == '0));

  // R7
  byte_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_size_i == 2'(SZ_B)) |-> (ra_data_o[XLEN-1:8] == '0));

  // R8
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && !illegal_o[1] && ra_size_i == 2'(SZ_Q) && phys[1] == phys[0])
      |=> (reg_q[$past(phys[0])] == $past(ra_data_o)));
endmodule

// File: tb/test_gpr_file.sv
module test_gpr_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lm = 1'b1;
  logic        wen = 1'b0;
  logic [3:0]  wnum = '0, anum = '0, bnum = '0;
  logic [1:0]  wsz = 2'd3, asz = 2'd3, bsz = 2'd3;
  logic        wrex = 1'b0, arex = 1'b0, brex = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] adata, bdata;
  logic [2:0]  ill;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [63:0] model [16];

  always #5 clk = ~clk;

  gpr_file i_gpr_file (
    .clk_i(clk), .rst_ni(rst_n), .long_mode_i(lm),
    .wr_en_i(wen), .wr_num_i(wnum), .wr_size_i(wsz), .wr_rex_i(wrex), .wr_data_i(wdata),
    .ra_num_i(anum), .ra_size_i(asz), .ra_rex_i(arex), .ra_data_o(adata),
    .rb_num_i(bnum), .rb_size_i(bsz), .rb_rex_i(brex), .rb_data_o(bdata),
    .illegal_o(ill)
  );

  function automatic void map_num(input int n, input int sz, input bit rx, input bit m,
                                  output int ph, output bit h, output bit il);
    il = !m && n >= 8;
    h  = sz == 0 && !(rx && m) && n >= 4 && n <= 7;
    ph = h ? n - 4 : n;
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] d,
                                        input int sz, input bit h);
    case (sz)
      0: return h ? ((o & ~64'hff00) | ({56'b0, d[7:0]} << 8)) : ((o & ~64'hff) | {56'b0, d[7:0]});
      1: return (o & ~64'hffff) | {48'b0, d[15:0]};
      2: return {32'b0, d[31:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [63:0] field(input logic [63:0] v, input int sz, input bit h);
    case (sz)
      0: return h ? {56'b0, v[15:8]} : {56'b0, v[7:0]};
      1: return {48'b0, v[15:0]};
      2: return {32'b0, v[31:0]};
      default: return v;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive on negedge, compare 1 ns later, update model at posedge
  task automatic step(input bit we, input int wn, input int ws, input bit wr, input logic [63:0] wd,
                      input int an, input int as, input bit ar,
                      input int bn, input int bs, input bit br,
                      input bit m, input string tag);
    int wp, ap, bp;
    bit wh, wi, ah, ai, bh, bi, wok;
    logic [63:0] nv, ea, eb;
    string ta, tb;
    wen = we; wnum = 4'(wn); wsz = 2'(ws); wrex = wr; wdata = wd;
    anum = 4'(an); asz = 2'(as); arex = ar;
    bnum = 4'(bn); bsz = 2'(bs); brex = br; lm = m;
    map_num(wn, ws, wr, m, wp, wh, wi);
    map_num(an, as, ar, m, ap, ah, ai);
    map_num(bn, bs, br, m, bp, bh, bi);
    wok = we && !wi;
    nv = merge(model[wp], wd, ws, wh);
    ea = ai ? 64'b0 : field((wok && ap == wp) ? nv : model[ap], as, ah);
    eb = bi ? 64'b0 : field((wok && bp == wp) ? nv : model[bp], bs, bh);
    ta = tag; tb = tag;
    if (tag == "") begin
      ta = ai ? "R9" : (wok && ap == wp) ? "R8" : (as != 3) ? "R7" : "R2";
      tb = bi ? "R9" : (wok && bp == wp) ? "R8" : (bs != 3) ? "R7" : "R2";
    end
    #1;
    check(ta, adata, ea);
    check(tb, bdata, eb);
    check("R9", {61'b0, ill}, {61'b0, bi, ai, wi && we});
    @(posedge clk);
    if (wok) model[wp] = nv;
    @(negedge clk);
  endtask

  task automatic rd(input int n, input int sz, input bit rx, input bit m, input string tag);
    step(0, 0, 3, 0, 64'h0, n, sz, rx, n, sz, rx, m, tag);
  endtask

  task automatic wr(input int n, input int sz, input bit rx, input logic [63:0] d);
    step(1, n, sz, rx, d, 0, 3, 0, 0, 3, 0, 1, "");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 16; i++) rd(i, 3, 0, 1, "R1");
    // R2 qword all registers
    for (int i = 0; i < 16; i++) wr(i, 3, 0, {8'(i), 56'h0123_4567_89ab_cd} ^ 64'hf0f0_0000_0000_0f0f);
    for (int i = 0; i < 16; i++) rd(i, 3, 0, 1, "R2");
    // R3 high bytes without REX
    for (int i = 4; i < 8; i++) wr(i, 0, 0, 64'(8'h10 + i));
    for (int i = 0; i < 4; i++) rd(i, 3, 0, 1, "R3");
    for (int i = 4; i < 8; i++) rd(i, 0, 0, 1, "R3");
    // R3 in legacy mode: REX ignored, still high byte
    rd(5, 0, 1, 0, "R3");
    // R4 REX makes 4..7 low bytes of regs 4..7, 8..15 low bytes
    for (int i = 4; i < 16; i++) wr(i, 0, 1, 64'(8'hc0 + i));
    for (int i = 0; i < 16; i++) rd(i, 3, 0, 1, "R4");
    for (int i = 4; i < 16; i++) rd(i, 0, 1, 1, "R4");
    // R5 dword clears upper half
    wr(3, 3, 0, 64'hffff_ffff_ffff_ffff);
    wr(3, 2, 0, 64'h1234_5678_9abc_def0);
    rd(3, 3, 0, 1, "R5");
    wr(12, 2, 1, 64'hdead_beef_0000_0001);
    rd(12, 3, 1, 1, "R5");
    // R6 word and byte merges
    wr(9, 3, 1, 64'haaaa_bbbb_cccc_dddd);
    wr(9, 1, 1, 64'h0000_0000_0000_1234);
    rd(9, 3, 1, 1, "R6");
    wr(9, 0, 1, 64'h77);
    rd(9, 3, 1, 1, "R6");
    // R7 narrow reads
    rd(9, 0, 1, 1, "R7"); rd(9, 1, 1, 1, "R7"); rd(9, 2, 1, 1, "R7");
    // R8 bypass
    step(1, 2, 3, 0, 64'h5555_6666_7777_8888, 2, 3, 0, 6, 0, 0, 1, "R8");
    step(1, 7, 0, 0, 64'h99, 3, 3, 0, 7, 0, 0, 1, "R8");
    // R9 legacy mode illegal write and reads
    step(1, 10, 3, 1, 64'h1, 10, 3, 1, 15, 0, 1, 0, "R9");
    rd(10, 3, 1, 1, "R9");
    step(0, 10, 3, 0, 64'h1, 2, 3, 0, 8, 3, 0, 0, "R9");
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      step(bit'($urandom), int'($urandom_range(0, 15)), int'($urandom_range(0, 3)), bit'($urandom), {$urandom, $urandom},
           int'($urandom_range(0, 15)), int'($urandom_range(0, 3)), bit'($urandom),
           int'($urandom_range(0, 15)), int'($urandom_range(0, 3)), bit'($urandom),
           ($urandom_range(0, 3) != 0), "");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule